// File: doc/BRIEF.md
# Mailbox-Commanded I2C Master

This block is an I2C bus master that software drives through four 16-bit registers. Software may first load a payload word into the write extension register. It then writes one command word to the command mailbox, and that write starts a short bus transaction. A transaction is a START (or repeated START), the 7-bit target address with its direction bit, and then zero, one or two data bytes in either direction. When the transaction completes, the engine sets one of three sticky event flags in the status register: transmit done, receive done or error. Bytes that were read are returned in the read extension register.

A command can ask the engine to keep the bus at its end. In that case no STOP is sent and SCL is held low, and the next command opens with a repeated START. Software uses this to build longer accesses from two-byte pieces, for example a register pointer write followed by a read. A command flagged as address-only sends no data bytes and serves as a presence probe. SCL and SDA are open-drain outputs: the block only ever pulls a line low. Each bit takes four quarter phases, and each quarter phase lasts `DIV_Q` clock cycles.

Top module: `i2c_mbox_master`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the engine is idle, and neither SCL nor SDA is pulled low.
- R2: A write to the command register (address 1) is accepted only when bits 15:14 equal 2'b10. Any other mode value is ignored: no bus activity and no flag change.
- R3: Status bit 0 reads 1 while a transaction is in progress. A command written during that time is ignored and does not disturb the running transfer.
- R4: Write command (bit 10 = 1). The engine sends the address byte {bits 7:1, R/W = 0}, then the payload from the write extension register (address 2): bits 7:0 first, and bits 15:8 second when bit 11 = 1. On success it sets status bit 14.
- R5: Read command (bit 10 = 0). The engine sends the address with R/W = 1 and reads one byte, or two when bit 11 = 1. On success the read extension register (address 3) holds the first byte in bits 7:0 and the second byte in bits 15:8, or zero when only one byte was read. Status bit 15 is set.
- R6: On a read, the master ACKs every byte except the last byte of the command, which it NACKs.
- R7: Command bit 12 selects an address-only probe, which sends no data byte. An acknowledged probe sets the done flag that matches bit 10. An unacknowledged probe sets the error flag.
- R8: A NACK on the address or on any written byte aborts the command. Status bit 13 is set instead of a done flag, and a STOP follows unless hold is requested.
- R9: With bit 13 set, the command ends without a STOP and SCL stays low. The next command begins with a repeated START.
- R10: Status bits 13 to 15 stay set until software writes 1 to them at status address 0. Writing 0 has no effect.
- R11: If a clear and a new event hit the same flag in the same cycle, the flag ends up set.
- R12: While SCL is released during address and data bits, SDA does not change. One bit lasts 4*DIV_Q clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 command, 2 write extension, 3 read extension |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected address (combinational) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
The bench builds the block with DIV_Q = 4, so each bit lasts 16 clocks and a full two-byte command takes a few hundred cycles. This short bit time lets one run cover many command chains, forced NACKs on the address and on data, and a flag clear that is retried every cycle until it lands in the exact cycle a transaction completes. At the default DIV_Q of 64 that coverage would need far more cycles. An open-drain target model on the bench counts START and STOP conditions and master ACKs, so hold-bus chaining and last-byte NACK can be observed from the bus itself.

// File: rtl/i2c_mbox_pkg.sv
// Shared definitions for the mailbox I2C master: register addresses,
// command and status bit positions, sequencer state and command fields.
package i2c_mbox_pkg;

    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_CMD    = 2'd1;
    localparam logic [1:0] RA_WEXT   = 2'd2;
    localparam logic [1:0] RA_REXT   = 2'd3;

    localparam int CB_WRITE = 10;
    localparam int CB_TWO   = 11;
    localparam int CB_PROBE = 12;
    localparam int CB_HOLD  = 13;

    localparam int SB_BUSY = 0;
    localparam logic [1:0] MODE_NATIVE = 2'b10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_START,
        SQ_BIT,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       is_write;
        logic       two;
        logic       probe;
        logic       hold;
    } cmd_t;

endpackage

// File: rtl/i2c_qtick_gen.sv
// Quarter-phase tick generator. While run is high it emits a one-cycle
// tick every DIV_Q clocks. While run is low the count is held at zero,
// so the first quarter of a transaction is always a full DIV_Q long.
// Assumes DIV_Q >= 1.
module i2c_qtick_gen #(
    parameter int DIV_Q = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_Q > 1) ? $clog2(DIV_Q) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_Q - 1);

    logic [CW-1:0] cnt;

    // Count clocks inside one quarter phase; restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/i2c_byte_sequencer.sv
// Bit-level I2C sequencer. On launch it latches the command and the payload,
// then produces START, the address byte, 0..2 data bytes and either a STOP
// or a bus hold, with four quarter phases per bit. done_stb is combinational
// and fires in the same cycle the engine returns to idle.
// Assumes launch is only asserted while idle; the target does not stretch SCL.
module i2c_byte_sequencer
    import i2c_mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        launch,
    input  cmd_t        cmd,
    input  logic [15:0] wdata,
    input  logic        sda_in,
    output logic        busy,
    output logic        held,
    output logic        in_bit,
    output logic [6:0]  addr_q,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        done_stb,
    output logic        done_err,
    output logic        done_rd,
    output logic [15:0] rx_word
);
    seq_state_e  st;
    logic [1:0]  q;
    logic [3:0]  bit_idx;
    logic [1:0]  byte_idx;
    logic [1:0]  nbytes;
    logic        rd_q;
    logic        hold_q;
    logic        err_q;
    logic        samp;
    logic [7:0]  shreg;
    logic [7:0]  rx_sh;
    logic [15:0] wbuf;

    logic tx_mode;
    logic last;
    logic fin;
    logic fin_err;

    assign tx_mode = (byte_idx == 2'd0) || !rd_q;
    assign last    = (byte_idx == nbytes);
    assign busy    = (st != SQ_IDLE);
    assign in_bit  = (st == SQ_BIT);
    assign done_rd = rd_q;

    // Decide at the end of an acknowledge slot whether the command finishes.
    always_comb begin
        fin     = 1'b0;
        fin_err = 1'b0;
        if (tick && st == SQ_BIT && q == 2'd3 && bit_idx == 4'd8) begin
            if (tx_mode && samp) begin
                fin     = 1'b1;
                fin_err = 1'b1;
            end else if (last) begin
                fin = 1'b1;
            end
        end
    end

    assign done_stb = (fin && hold_q) || (tick && st == SQ_STOP && q == 2'd3);
    assign done_err = (st == SQ_BIT) ? fin_err : err_q;

    // Main sequencing: latch a command, then step quarter phases on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            q        <= 2'd0;
            bit_idx  <= 4'd0;
            byte_idx <= 2'd0;
            nbytes   <= 2'd0;
            rd_q     <= 1'b0;
            hold_q   <= 1'b0;
            err_q    <= 1'b0;
            samp     <= 1'b1;
            shreg    <= 8'hFF;
            rx_sh    <= 8'h00;
            wbuf     <= 16'h0000;
            addr_q   <= 7'd0;
            held     <= 1'b0;
            rx_word  <= 16'h0000;
        end else if (launch && st == SQ_IDLE) begin
            st       <= SQ_START;
            q        <= 2'd0;
            bit_idx  <= 4'd0;
            byte_idx <= 2'd0;
            nbytes   <= cmd.probe ? 2'd0 : (cmd.two ? 2'd2 : 2'd1);
            rd_q     <= !cmd.is_write;
            hold_q   <= cmd.hold;
            err_q    <= 1'b0;
            shreg    <= {cmd.addr, !cmd.is_write};
            wbuf     <= wdata;
            addr_q   <= cmd.addr;
            held     <= 1'b0;
            rx_word  <= 16'h0000;
        end else if (tick) begin
            q <= q + 2'd1;
            case (st)
                SQ_START: begin
                    if (q == 2'd3) st <= SQ_BIT;
                end
                SQ_BIT: begin
                    if (q == 2'd2) begin
                        samp <= sda_in;
                        if (!tx_mode && bit_idx != 4'd8) rx_sh <= {rx_sh[6:0], sda_in};
                    end
                    if (q == 2'd3) begin
                        if (bit_idx != 4'd8) begin
                            bit_idx <= bit_idx + 4'd1;
                            shreg   <= {shreg[6:0], 1'b1};
                            if (!tx_mode && bit_idx == 4'd7) begin
                                if (byte_idx == 2'd1) rx_word[7:0]  <= rx_sh;
                                else                  rx_word[15:8] <= rx_sh;
                            end
                        end else if (fin) begin
                            err_q <= fin_err;
                            if (hold_q) begin
                                st   <= SQ_IDLE;
                                held <= 1'b1;
                            end else begin
                                st <= SQ_STOP;
                            end
                        end else begin
                            bit_idx  <= 4'd0;
                            byte_idx <= byte_idx + 2'd1;
                            shreg    <= (byte_idx == 2'd0) ? wbuf[7:0] : wbuf[15:8];
                        end
                    end
                end
                SQ_STOP: begin
                    if (q == 2'd3) begin
                        st   <= SQ_IDLE;
                        held <= 1'b0;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Open-drain line drive for each state and quarter phase.
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (st)
            SQ_IDLE: begin
                scl_oe = held;
                sda_oe = 1'b0;
            end
            SQ_START: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = q[1];
            end
            SQ_BIT: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                if (bit_idx == 4'd8) sda_oe = !tx_mode && !last;
                else                 sda_oe = tx_mode && !shreg[7];
            end
            SQ_STOP: begin
                scl_oe = (q == 2'd0);
                sda_oe = !q[1];
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2c_mbox_regfile.sv
// Register file: status with write-one-to-clear event flags and a busy bit,
// the command mailbox (launch decode), and the write and read extension
// words. Assumes done_stb is a single-cycle strobe from the sequencer.
module i2c_mbox_regfile
    import i2c_mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        busy,
    input  logic        done_stb,
    input  logic        done_err,
    input  logic        done_rd,
    input  logic [15:0] rx_word,
    output logic        launch,
    output cmd_t        cmd,
    output logic [15:0] wdata,
    output logic [2:0]  flags
);
    logic [15:0] rext;
    logic [2:0]  clr;
    logic [2:0]  set;

    assign launch = reg_wr && (reg_addr == RA_CMD)
                    && (reg_wdata[15:14] == MODE_NATIVE) && !busy;

    assign cmd.addr     = reg_wdata[7:1];
    assign cmd.is_write = reg_wdata[CB_WRITE];
    assign cmd.two      = reg_wdata[CB_TWO];
    assign cmd.probe    = reg_wdata[CB_PROBE];
    assign cmd.hold     = reg_wdata[CB_HOLD];

    assign clr = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata[15:13] : 3'b000;
    assign set = {done_stb && !done_err && done_rd,
                  done_stb && !done_err && !done_rd,
                  done_stb && done_err};

    // Event flags {rx, tx, err}: clear by writing one, a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= 3'b000;
        else        flags <= (flags & ~clr) | set;
    end

    // Write extension word, loaded by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                              wdata <= 16'h0000;
        else if (reg_wr && reg_addr == RA_WEXT)  wdata <= reg_wdata;
    end

    // Read extension word, updated when a read finishes without error.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rext <= 16'h0000;
        else if (done_stb && !done_err && done_rd)  rext <= rx_word;
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            RA_STATUS: reg_rdata = {flags, 12'h000, busy};
            RA_WEXT:   reg_rdata = wdata;
            RA_REXT:   reg_rdata = rext;
            default:   reg_rdata = 16'h0000;
        endcase
    end

endmodule

// File: rtl/i2c_mbox_master.sv
// Top level of the mailbox-commanded I2C master: register file, quarter
// tick divider and bit sequencer. Open-drain outputs: *_oe = 1 pulls low.
// Assumes sda_in is already synchronised to clk.
module i2c_mbox_master
    import i2c_mbox_pkg::*;
#(
    parameter int DIV_Q = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    logic        launch;
    cmd_t        cmd;
    logic [15:0] wdata;
    logic [2:0]  flags;
    logic        tick;
    logic        seq_busy;
    logic        seq_held;
    logic        seq_in_bit;
    logic [6:0]  seq_addr_q;
    logic        done_stb;
    logic        done_err;
    logic        done_rd;
    logic [15:0] rx_word;
    logic        cmd_wr_busy;

    assign cmd_wr_busy = reg_wr && (reg_addr == RA_CMD) && seq_busy;

    i2c_mbox_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (seq_busy),
        .done_stb  (done_stb),
        .done_err  (done_err),
        .done_rd   (done_rd),
        .rx_word   (rx_word),
        .launch    (launch),
        .cmd       (cmd),
        .wdata     (wdata),
        .flags     (flags)
    );

    i2c_qtick_gen #(.DIV_Q(DIV_Q)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_busy),
        .tick  (tick)
    );

    i2c_byte_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .launch   (launch),
        .cmd      (cmd),
        .wdata    (wdata),
        .sda_in   (sda_in),
        .busy     (seq_busy),
        .held     (seq_held),
        .in_bit   (seq_in_bit),
        .addr_q   (seq_addr_q),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .done_stb (done_stb),
        .done_err (done_err),
        .done_rd  (done_rd),
        .rx_word  (rx_word)
    );

endmodule

// File: rtl/i2c_mbox_checker.sv
// Property checker for i2c_mbox_master, attached by bind. It observes bus
// drive, sequencer state and the event flags; it drives nothing.
module i2c_mbox_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        busy,
    input logic        held,
    input logic        in_bit,
    input logic [6:0]  addr_q,
    input logic        cmd_wr_busy,
    input logic        done_stb,
    input logic        done_err,
    input logic        done_rd,
    input logic [2:0]  flags
);
    logic clr_tx;
    assign clr_tx = reg_wr && (reg_addr == 2'd0) && reg_wdata[14];

    p_idle_sda_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);

    p_busy_cmd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_busy |=> $stable(addr_q));

    p_error_not_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && done_err) |=> (flags[0] && !$rose(flags[1]) && !$rose(flags[2])));

    p_hold_keeps_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && held) |-> scl_oe);

    p_tx_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !clr_tx) |=> flags[1]);

    p_rx_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && !done_err && done_rd) |=> flags[2]);

    p_tx_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && !done_err && !done_rd) |=> flags[1]);

    p_sda_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bit && !scl_oe && $past(in_bit) && $past(!scl_oe)) |-> $stable(sda_oe));

endmodule

bind i2c_mbox_master i2c_mbox_checker u_i2c_mbox_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .busy        (seq_busy),
    .held        (seq_held),
    .in_bit      (seq_in_bit),
    .addr_q      (seq_addr_q),
    .cmd_wr_busy (cmd_wr_busy),
    .done_stb    (done_stb),
    .done_err    (done_err),
    .done_rd     (done_rd),
    .flags       (flags)
);

// File: tb/test_i2c_mbox_master.sv
// Directed bench for i2c_mbox_master with an open-drain target model at 0x50.
module test_i2c_mbox_master;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DIV_Q = 4;
    localparam logic [6:0] SLV_ADDR = 7'h50;
    localparam int M_ADDR = 0, M_WR = 1, M_RD = 2, M_IGN = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        scl_oe, sda_oe;
    logic        s_oe = 1'b0;
    wire         scl_line = ~scl_oe;
    wire         sda_line = ~(sda_oe | s_oe);

    int checks = 0;
    int fails  = 0;

    i2c_mbox_master #(.DIV_Q(DIV_Q)) i_i2c_mbox_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sda_in    (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    always #4 clk = ~clk;

    // ---------------- target model ----------------
    logic       s_act = 1'b0;
    logic       s_skip = 1'b0;
    int         s_mode = M_IGN;
    int         s_cnt = 0;
    logic [7:0] s_sh = 8'h0;
    logic [7:0] s_cur = 8'h0;
    logic [7:0] s_addr_byte = 8'h0;
    logic       s_ack = 1'b0;
    logic       s_mack = 1'b0;
    logic [7:0] rd_mem [4];
    logic [7:0] wr_log [8];
    int rd_i = 0, wr_n = 0, rx_n = 0, nack_at = -1;
    int start_cnt = 0, stop_cnt = 0, mack_cnt = 0, mnack_cnt = 0;

    always @(negedge sda_line) if (scl_line) begin
        s_act = 1'b1; s_mode = M_ADDR; s_cnt = 0; s_skip = 1'b1; s_oe = 1'b0;
        start_cnt++;
    end

    always @(posedge sda_line) if (scl_line) begin
        s_act = 1'b0; s_oe = 1'b0; stop_cnt++;
    end

    always @(posedge scl_line) if (s_act) begin
        if (s_cnt < 8 && (s_mode == M_ADDR || s_mode == M_WR)) begin
            s_sh = {s_sh[6:0], sda_line};
        end else if (s_cnt == 8 && s_mode == M_RD) begin
            s_mack = ~sda_line;
            if (s_mack) mack_cnt++; else mnack_cnt++;
        end
    end

    always @(negedge scl_line) if (s_act) begin
        if (s_skip) begin
            s_skip = 1'b0;
        end else if (s_cnt < 7) begin
            s_cnt++;
            if (s_mode == M_RD) s_oe = ~s_cur[7 - s_cnt];
        end else if (s_cnt == 7) begin
            s_cnt = 8;
            if (s_mode == M_ADDR) begin
                s_addr_byte = s_sh;
                s_ack = (s_sh[7:1] == SLV_ADDR);
                s_oe = s_ack;
            end else if (s_mode == M_WR) begin
                s_ack = (rx_n != nack_at);
                rx_n++;
                if (s_ack) begin wr_log[wr_n & 7] = s_sh; wr_n++; end
                s_oe = s_ack;
            end else begin
                s_oe = 1'b0;
            end
        end else begin
            s_cnt = 0; s_oe = 1'b0;
            if (s_mode == M_ADDR) begin
                if (!s_ack) s_mode = M_IGN;
                else if (s_addr_byte[0]) begin
                    s_mode = M_RD; s_cur = rd_mem[rd_i & 3]; rd_i++; s_oe = ~s_cur[7];
                end else s_mode = M_WR;
            end else if (s_mode == M_WR) begin
                if (!s_ack) s_mode = M_IGN;
            end else if (s_mode == M_RD) begin
                if (s_mack) begin s_cur = rd_mem[rd_i & 3]; rd_i++; s_oe = ~s_cur[7]; end
                else s_mode = M_IGN;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        s = 16'h0001;
        while (s[0]) rd_reg(2'd0, s);
    endtask

    function automatic logic [15:0] mk_cmd(input logic [6:0] a, input logic wr,
            input logic two, input logic probe, input logic hold);
        return {2'b10, hold, probe, two, wr, 2'b00, a, 1'b0};
    endfunction

    task automatic clear_flags();
        wr_reg(2'd0, 16'hE000);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [15:0] v;
        rd_reg(2'd0, v); chk("R1 status after reset", v, 16'h0000);
        rd_reg(2'd3, v); chk("R1 read ext after reset", v, 16'h0000);
        rd_reg(2'd2, v); chk("R1 write ext after reset", v, 16'h0000);
        chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
    endtask

    task automatic t_write_two();
        logic [15:0] v;
        time t0, t1;
        int st0, sp0;
        st0 = start_cnt; sp0 = stop_cnt; wr_n = 0; rx_n = 0; nack_at = -1;
        clear_flags();
        wr_reg(2'd2, 16'h3CA5);
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b1, 1'b0, 1'b0));
        @(posedge scl_line); t0 = $time;
        @(posedge scl_line); t1 = $time;
        chk("R12 bit period ns", 32'(t1 - t0), 32'(4 * DIV_Q * 8));
        wait_idle();
        rd_reg(2'd0, v); chk("R4 tx flag", v, 16'h4000);
        chk("R4 address byte", {24'h0, s_addr_byte}, 32'hA0);
        chk("R4 byte count", wr_n, 2);
        chk("R4 first byte low half", {24'h0, wr_log[0]}, 32'hA5);
        chk("R4 second byte high half", {24'h0, wr_log[1]}, 32'h3C);
        chk("R4 one start one stop", {start_cnt - st0, stop_cnt - sp0}, {32'd1, 32'd1});
    endtask

    task automatic t_read_two();
        logic [15:0] v;
        int ma, mn;
        ma = mack_cnt; mn = mnack_cnt;
        rd_mem[0] = 8'h81; rd_mem[1] = 8'h7E; rd_i = 0;
        clear_flags();
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b0, 1'b1, 1'b0, 1'b0));
        wait_idle();
        rd_reg(2'd0, v); chk("R5 rx flag", v, 16'h8000);
        rd_reg(2'd3, v); chk("R5 read ext two bytes", v, 16'h7E81);
        chk("R5 address byte read", {24'h0, s_addr_byte}, 32'hA1);
        chk("R6 acks then nack", {mack_cnt - ma, mnack_cnt - mn}, {32'd1, 32'd1});
    endtask

    task automatic t_read_one();
        logic [15:0] v;
        int ma, mn;
        ma = mack_cnt; mn = mnack_cnt;
        rd_mem[0] = 8'hC3; rd_i = 0;
        clear_flags();
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b0, 1'b0, 1'b0, 1'b0));
        wait_idle();
        rd_reg(2'd3, v); chk("R5 read ext one byte", v, 16'h00C3);
        chk("R6 single byte nacked", {mack_cnt - ma, mnack_cnt - mn}, {32'd0, 32'd1});
    endtask

    task automatic t_probe();
        logic [15:0] v;
        int sp0;
        wr_n = 0; rx_n = 0; sp0 = stop_cnt;
        clear_flags();
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b0, 1'b1, 1'b0));
        wait_idle();
        rd_reg(2'd0, v); chk("R7 present probe done", v, 16'h4000);
        chk("R7 probe sends no data", wr_n, 0);
        clear_flags();
        wr_reg(2'd1, mk_cmd(7'h33, 1'b1, 1'b0, 1'b1, 1'b0));
        wait_idle();
        rd_reg(2'd0, v); chk("R7 absent probe error", v, 16'h2000);
        chk("R8 stop after address nack", stop_cnt - sp0, 2);
    endtask

    task automatic t_data_nack();
        logic [15:0] v;
        int st0, sp0;
        wr_n = 0; rx_n = 0; nack_at = 0; st0 = start_cnt; sp0 = stop_cnt;
        clear_flags();
        wr_reg(2'd2, 16'h6655);
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b1, 1'b0, 1'b0));
        wait_idle();
        nack_at = -1;
        rd_reg(2'd0, v); chk("R8 data nack error only", v, 16'h2000);
        chk("R8 second byte not sent", rx_n, 1);
        chk("R8 stop after data nack", {start_cnt - st0, stop_cnt - sp0}, {32'd1, 32'd1});
    endtask

    task automatic t_hold_chain();
        logic [15:0] v;
        int st0, sp0;
        st0 = start_cnt; sp0 = stop_cnt; wr_n = 0; rx_n = 0;
        rd_mem[0] = 8'h9A; rd_mem[1] = 8'hBC; rd_i = 0;
        clear_flags();
        wr_reg(2'd2, 16'h0011);
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b0, 1'b0, 1'b1));
        wait_idle();
        rd_reg(2'd0, v); chk("R9 held write done", v, 16'h4000);
        chk("R9 no stop while held", stop_cnt - sp0, 0);
        repeat (20) @(negedge clk);
        chk("R9 scl kept low", scl_oe, 1'b1);
        clear_flags();
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b0, 1'b1, 1'b0, 1'b0));
        wait_idle();
        chk("R9 repeated start", start_cnt - st0, 2);
        chk("R9 single stop at chain end", stop_cnt - sp0, 1);
        rd_reg(2'd3, v); chk("R9 chained read data", v, 16'hBC9A);
        chk("R9 pointer byte", {24'h0, wr_log[0]}, 32'h11);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        int st0;
        st0 = start_cnt; wr_n = 0; rx_n = 0;
        clear_flags();
        wr_reg(2'd2, 16'h00A5);
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b0, 1'b0, 1'b0));
        rd_reg(2'd0, v); chk("R3 busy bit set", {31'h0, v[0]}, 32'd1);
        wr_reg(2'd1, mk_cmd(7'h51, 1'b1, 1'b1, 1'b0, 1'b0));
        wait_idle();
        chk("R3 one transaction", start_cnt - st0, 1);
        chk("R3 original address kept", {24'h0, s_addr_byte}, 32'hA0);
        chk("R3 original length kept", wr_n, 1);
    endtask

    task automatic t_non_native();
        logic [15:0] v;
        int st0;
        st0 = start_cnt;
        clear_flags();
        wr_reg(2'd1, 16'h44A0);
        repeat (40) @(negedge clk);
        rd_reg(2'd0, v); chk("R2 foreign mode no busy no flag", v, 16'h0000);
        chk("R2 no bus activity", start_cnt - st0, 0);
        chk("R2 lines released", {scl_oe, sda_oe}, 2'b00);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        clear_flags();
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b0, 1'b1, 1'b0));
        wait_idle();
        repeat (5) @(negedge clk);
        rd_reg(2'd0, v); chk("R10 flag sticky", v, 16'h4000);
        wr_reg(2'd0, 16'hA000);
        rd_reg(2'd0, v); chk("R10 other bits leave tx", v, 16'h4000);
        wr_reg(2'd0, 16'h4000);
        rd_reg(2'd0, v); chk("R10 write one clears", v, 16'h0000);
    endtask

    task automatic t_collision();
        logic [15:0] s;
        clear_flags();
        wr_reg(2'd1, mk_cmd(SLV_ADDR, 1'b1, 1'b0, 1'b1, 1'b0));
        s = 16'h0001;
        while (s[0]) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 2'd0; #1; s = reg_rdata;
            if (s[0]) begin reg_wdata = 16'hE000; reg_wr = 1'b1; end
        end
        reg_wr = 1'b0;
        rd_reg(2'd0, s); chk("R11 event beats clear", s, 16'h4000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1-wide run actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_two();
        t_read_two();
        t_read_one();
        t_probe();
        t_data_nack();
        t_hold_chain();
        t_busy_ignore();
        t_non_native();
        t_w1c();
        t_collision();
        finish_run();
    end

endmodule